// File: doc/BRIEF.md
# Keyboard Receiver Register Block

This block lets a processor poll a keyboard receiver through ordinary loads on its load/store bus. The keyboard side hands over one ASCII character at a time with a one-cycle strobe. The block captures the character and raises a ready flag. Software loops on a byte load of the status word until the flag is set, then loads the character. That load also clears the flag.

Both registers sit in an I/O page that is selected when the upper half of the address is all ones. The status word is at page offset 0xC and the character is at page offset 0x8. Read data is returned in the same cycle the access is presented, zero-extended to the bus width. A character that arrives before the previous one was read replaces it and sets a sticky overrun bit. Reset is asynchronous and active-low, and its release is synchronised to the clock.

Top module: `kbd_rx_mmio`

## Requirements
- R1: An access whose address bits 31:16 differ from 0xFFFF returns zero on `bus_rdata` and changes neither the ready flag nor the held character.
- R2: A read at address 0xFFFF000C returns the status word: the ready flag at bit 1, the overrun flag at bit 2, and every other bit 0.
- R3: A read at address 0xFFFF0008 returns the held character in bits 7:0, with bits 31:8 equal to 0.
- R4: A `kb_strobe` pulse loads `kb_char` into the character register and sets the ready flag, both visible from the next cycle.
- R5: An accepted read at 0xFFFF0008 clears the ready flag from the next cycle. A read of the status word leaves the flag unchanged.
- R6: A strobe that arrives while the ready flag is set, with no character read in the same cycle, replaces the character and sets the overrun flag. The overrun flag then stays set until reset.
- R7: If a strobe and a character read fall in the same cycle, the read returns the old character. The new character is loaded, the ready flag stays set and no overrun is recorded.
- R8: Reads at any other offset in the page return zero. Writes anywhere in the page change neither flag nor the character.
- R9: While `rst_n` is low, the character, ready and overrun registers read as zero and strobes are ignored. The block leaves reset two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_rdata | output | 32 | Read data, combinational from the address and the register state |
| kb_strobe | input | 1 | One-cycle pulse: a new character is present |
| kb_char | input | 8 | ASCII character from the keyboard side |

## Verification
The delicate cycle is one in which a keyboard strobe and an accepted character read fall on the same clock edge. There the set of the ready flag must win over its clear, and the overrun flag must stay untouched because the old character was consumed. The bench provokes this by holding a strobe with a new character while it reads offset 0x8 with the flag already set. It then judges three things: the returned byte must be the old character, the following status read must show 0x2, and the next character read must return the new byte. The contrasting case, a strobe with the flag set and no read, must instead yield status 0x6.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

  // Which register, if any, a read access targets
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/kbd_rx_rst_sync.sv
module kbd_rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/kbd_rx_decode.sv
module kbd_rx_decode
  import kbd_rx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFS_W    = 16,
  parameter logic [ADDR_W-OFS_W-1:0] PAGE_TAG = '1,
  parameter logic [OFS_W-1:0] CTRL_OFS = 16'h000C,
  parameter logic [OFS_W-1:0] DATA_OFS = 16'h0008
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          rd_sel
);

  logic page_hit;
  logic rd_req;

  always_comb begin
    page_hit = (bus_addr[ADDR_W-1:OFS_W] == PAGE_TAG);
    rd_req   = bus_sel & ~bus_we & page_hit;
    rd_sel   = SEL_NONE;
    if (rd_req) begin
      if (bus_addr[OFS_W-1:0] == CTRL_OFS)      rd_sel = SEL_CTRL;
      else if (bus_addr[OFS_W-1:0] == DATA_OFS) rd_sel = SEL_DATA;
    end
  end

endmodule

// File: rtl/kbd_rx_state.sv
module kbd_rx_state #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              kb_strobe,
  input  logic [CHAR_W-1:0] kb_char,
  input  logic              data_rd,
  output logic [CHAR_W-1:0] char_q,
  output logic              ready_q,
  output logic              ovr_q
);

  logic [CHAR_W-1:0] char_d;
  logic              char_en;
  logic              ready_d;
  logic              ready_en;
  logic              ovr_d;
  logic              ovr_en;

  // Next-state logic: a strobe sets ready even if a read clears it
  always_comb begin
    char_en  = kb_strobe;
    char_d   = kb_char;
    ready_en = kb_strobe | data_rd;
    ready_d  = kb_strobe;
    ovr_en   = kb_strobe & ready_q & ~data_rd;
    ovr_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      char_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (char_en)  char_q  <= char_d;
      if (ready_en) ready_q <= ready_d;
      if (ovr_en)   ovr_q   <= ovr_d;
    end
  end

endmodule

// File: rtl/kbd_rx_rdmux.sv
module kbd_rx_rdmux
  import kbd_rx_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHAR_W  = 8,
  parameter int unsigned RDY_BIT = 1,
  parameter int unsigned OVR_BIT = 2
) (
  input  reg_sel_e          rd_sel,
  input  logic [CHAR_W-1:0] char_q,
  input  logic              ready_q,
  input  logic              ovr_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] data_word;

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[RDY_BIT] = ready_q;
    ctrl_word[OVR_BIT] = ovr_q;
  end

  generate
    if (DATA_W > CHAR_W) begin : g_pad
      assign data_word = {{(DATA_W-CHAR_W){1'b0}}, char_q};
    end else begin : g_full
      assign data_word = char_q[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: rdata = ctrl_word;
      SEL_DATA: rdata = data_word;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/kbd_rx_mmio.sv
module kbd_rx_mmio
  import kbd_rx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CHAR_W   = 8,
  parameter logic [ADDR_W-OFS_W-1:0] PAGE_TAG = '1,
  parameter logic [OFS_W-1:0] CTRL_OFS = 16'h000C,
  parameter logic [OFS_W-1:0] DATA_OFS = 16'h0008,
  parameter int unsigned RDY_BIT  = 1,
  parameter int unsigned OVR_BIT  = 2,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_strobe,
  input  logic [CHAR_W-1:0] kb_char
);

  logic              rst_sync_n;
  reg_sel_e          rd_sel;
  logic              data_rd;
  logic [CHAR_W-1:0] char_q;
  logic              ready_q;
  logic              ovr_q;

  kbd_rx_rst_sync #(
    .STAGES (SYNC_STG)
  ) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kbd_rx_decode #(
    .ADDR_W   (ADDR_W),
    .OFS_W    (OFS_W),
    .PAGE_TAG (PAGE_TAG),
    .CTRL_OFS (CTRL_OFS),
    .DATA_OFS (DATA_OFS)
  ) decode_i (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .rd_sel   (rd_sel)
  );

  assign data_rd = (rd_sel == SEL_DATA);

  kbd_rx_state #(
    .CHAR_W (CHAR_W)
  ) state_i (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .kb_strobe  (kb_strobe),
    .kb_char    (kb_char),
    .data_rd    (data_rd),
    .char_q     (char_q),
    .ready_q    (ready_q),
    .ovr_q      (ovr_q)
  );

  kbd_rx_rdmux #(
    .DATA_W  (DATA_W),
    .CHAR_W  (CHAR_W),
    .RDY_BIT (RDY_BIT),
    .OVR_BIT (OVR_BIT)
  ) rdmux_i (
    .rd_sel  (rd_sel),
    .char_q  (char_q),
    .ready_q (ready_q),
    .ovr_q   (ovr_q),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/kbd_rx_mmio_chk.sv
module kbd_rx_mmio_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CHAR_W   = 8,
  parameter logic [ADDR_W-OFS_W-1:0] PAGE_TAG = '1,
  parameter logic [OFS_W-1:0] CTRL_OFS = 16'h000C,
  parameter int unsigned RDY_BIT  = 1,
  parameter int unsigned OVR_BIT  = 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kb_strobe,
  input logic [CHAR_W-1:0] kb_char,
  input logic              data_rd,
  input logic [CHAR_W-1:0] char_q,
  input logic              ready_q,
  input logic              ovr_q
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = {PAGE_TAG, CTRL_OFS};

  AST_OFF_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_sel && (bus_addr[ADDR_W-1:OFS_W] != PAGE_TAG) |-> bus_rdata == '0); // R1

  AST_CTRL_SHAPE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_sel && !bus_we && (bus_addr == CTRL_ADDR) |->
      (bus_rdata[RDY_BIT] == ready_q) && (bus_rdata[OVR_BIT] == ovr_q) &&
      ($countones(bus_rdata) == (32'(ready_q) + 32'(ovr_q)))); // R2

  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[DATA_W-1:CHAR_W] == '0); // R3

  AST_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kb_strobe |=> ready_q && (char_q == $past(kb_char))); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_rd && !kb_strobe |=> !ready_q); // R5

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovr_q |=> ovr_q); // R6

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ovr_q) |-> $past(kb_strobe && ready_q && !data_rd)); // R6

  AST_SAME_CYCLE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kb_strobe && data_rd && !ovr_q |=> !ovr_q && ready_q); // R7

  AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_sel && bus_we && !kb_strobe |=> $stable(ready_q) && $stable(char_q)); // R8

endmodule

bind kbd_rx_mmio kbd_rx_mmio_chk #(
  .ADDR_W   (ADDR_W),
  .OFS_W    (OFS_W),
  .DATA_W   (DATA_W),
  .CHAR_W   (CHAR_W),
  .PAGE_TAG (PAGE_TAG),
  .CTRL_OFS (CTRL_OFS),
  .RDY_BIT  (RDY_BIT),
  .OVR_BIT  (OVR_BIT)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .kb_strobe  (kb_strobe),
  .kb_char    (kb_char),
  .data_rd    (data_rd),
  .char_q     (char_q),
  .ready_q    (ready_q),
  .ovr_q      (ovr_q)
);

// File: tb/kbd_rx_mmio_tb_top.sv
`timescale 1ns/1ps
module kbd_rx_mmio_tb_top;

  localparam logic [31:0] A_CTRL = 32'hFFFF_000C;
  localparam logic [31:0] A_DATA = 32'hFFFF_0008;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [31:0] bus_rdata;
  logic        kb_strobe;
  logic [7:0]  kb_char;

  int checks;
  int failures;

  // Bench-side model of the architected state
  logic       m_ready;
  logic       m_ovr;
  logic [7:0] m_char;

  kbd_rx_mmio dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .kb_strobe (kb_strobe),
    .kb_char   (kb_char)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic sel, input logic we, input logic [31:0] addr);
    if (sel && !we && addr[31:16] == 16'hFFFF) begin
      if (addr[15:0] == 16'h000C) return {29'd0, m_ovr, m_ready, 1'b0};
      if (addr[15:0] == 16'h0008) return {24'd0, m_char};
    end
    return 32'd0;
  endfunction

  // One bus cycle: drive at the falling edge, compare before the rising edge,
  // then advance the model to the state after that rising edge.
  task automatic op(input logic sel, input logic we, input logic [31:0] addr,
                    input logic stb, input logic [7:0] ch, input string tag);
    logic rd;
    @(negedge clk);
    bus_sel   = sel;
    bus_we    = we;
    bus_addr  = addr;
    kb_strobe = stb;
    kb_char   = ch;
    #2;
    check(tag, bus_rdata, model_read(sel, we, addr));
    rd = sel && !we && (addr == A_DATA);
    if (stb) begin
      if (m_ready && !rd) m_ovr = 1'b1;
      m_ready = 1'b1;
      m_char  = ch;
    end else if (rd) begin
      m_ready = 1'b0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; kb_strobe = 1'b0; kb_char = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_CTRL; kb_strobe = 1'b0;
    #2;
    check("R9 status in reset", bus_rdata, 32'd0);
    bus_addr = A_DATA;
    #1;
    check("R9 char in reset", bus_rdata, 32'd0);
    @(negedge clk);
    bus_sel = 1'b0; kb_strobe = 1'b1; kb_char = 8'hC3;   // R9: ignored in reset
    @(negedge clk);
    kb_strobe = 1'b0;
    rst_n = 1'b1;
    m_ready = 1'b0; m_ovr = 1'b0; m_char = '0;
    repeat (3) idle();
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    m_ready = 1'b0; m_ovr = 1'b0; m_char = '0;
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; kb_strobe = 1'b0; kb_char = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();

    // R9: reset state
    op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R9 status after reset");
    op(1'b1, 1'b0, A_DATA, 1'b0, 8'h00, "R9 char after reset");

    // R4 R2 R3 R5: every character value
    for (int v = 0; v < 256; v++) begin
      op(1'b0, 1'b0, '0, 1'b1, 8'(v), "R4 strobe cycle");
      op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R2 status ready");
      op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R5 status read keeps ready");
      op(1'b1, 1'b0, A_DATA, 1'b0, 8'h00, "R3 char read");
      op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R5 ready cleared");
    end

    // R8: sweep of page offsets with a character pending
    op(1'b0, 1'b0, '0, 1'b1, 8'h5A, "R4 load");
    for (int o = 0; o < 40; o++) begin
      op(1'b1, 1'b0, 32'hFFFF_0000 + 32'(o), 1'b0, 8'h00, "R8 offset sweep");
    end
    op(1'b0, 1'b0, '0, 1'b1, 8'h77, "R4 load");
    op(1'b1, 1'b0, 32'hFFFF_0100, 1'b0, 8'h00, "R8 far offset");
    op(1'b1, 1'b1, A_DATA, 1'b0, 8'h00, "R8 write char reg");
    op(1'b1, 1'b1, A_CTRL, 1'b0, 8'h00, "R8 write status reg");
    op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R8 status after writes");

    // R1: off-page accesses
    op(1'b1, 1'b0, 32'hFFFE_0008, 1'b0, 8'h00, "R1 off page char");
    op(1'b1, 1'b0, 32'h0000_000C, 1'b0, 8'h00, "R1 off page status");
    op(1'b1, 1'b0, 32'h7FFF_0008, 1'b0, 8'h00, "R1 off page char");
    op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R1 ready untouched");
    op(1'b1, 1'b0, A_DATA, 1'b0, 8'h00, "R1 char untouched");

    // R7: strobe and char read in the same cycle
    op(1'b0, 1'b0, '0, 1'b1, 8'h41, "R4 load");
    op(1'b1, 1'b0, A_DATA, 1'b1, 8'h42, "R7 read returns old char");
    op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R7 ready kept, no overrun");
    op(1'b1, 1'b0, A_DATA, 1'b0, 8'h00, "R7 new char held");

    // R6: overrun
    op(1'b0, 1'b0, '0, 1'b1, 8'h10, "R4 load");
    op(1'b0, 1'b0, '0, 1'b1, 8'h20, "R6 second strobe");
    op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R6 status overrun");
    op(1'b1, 1'b0, A_DATA, 1'b0, 8'h00, "R6 char replaced");
    op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R6 overrun sticky");
    op(1'b0, 1'b0, '0, 1'b1, 8'h30, "R4 load");
    op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R6 overrun still set");

    // R9: reset mid-run, strobe ignored while held
    do_reset();
    op(1'b1, 1'b0, A_CTRL, 1'b0, 8'h00, "R9 status cleared");
    op(1'b1, 1'b0, A_DATA, 1'b0, 8'h00, "R9 char cleared");

    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule